// File: doc/BRIEF.md
# Three-Value Combination Lock Controller

This block is the control and compare logic of a keypad-style door lock. A user enters a sequence of 4-bit values, each one qualified by a single-cycle strobe. The block compares every entered value against the stored combination digit for the current position. When all three digits match in order, the lock opens. A wrong digit at any position sends the block to a dead error state. The block leaves both the open state and the error state only through reset.

The design splits into a controller and a datapath. The controller is a small state machine. The datapath is a one-hot selector, which picks the combination digit for the current position, and an equality comparator, which returns a match flag to the controller. The state encoding is chosen so that the selector's one-hot control and the open output come straight from the state register bits. No separate output flops are needed. Surrounding logic holds the combination digits stable on the combination input. How those digits are loaded is outside this block.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycles after its synchronised release, the block is in the first-digit state with the lock closed (`open_o` = 0). No digit has been accepted yet.
- R2: In digit state k (k = 1, 2, 3), a strobe whose value equals digit k advances the block by one position. The third match opens the lock. `open_o` rises at the clock edge that samples the third matching strobe, and not earlier. Digit k occupies `combo_i[4k-1:4k-4]`.
- R3: With `strobe_i` low, the value input has no effect and the state holds, whatever the value is.
- R4: In any digit state, a strobe whose value differs from the selected digit moves the block to the error state. The lock is then closed.
- R5: Once open, the lock stays open through any further strobes and values until reset.
- R6: Once in the error state, the lock stays closed until reset. This holds even if the full correct sequence is entered afterwards.
- R7: Reset overrides every state. After reset, the full three-digit sequence is needed again to open the lock.
- R8: The state register is 4 bits wide. The encodings are: first digit 0001, second 0010, third 0100, open 1000, error 0000. The selector's one-hot control is the low three state bits. `open_o` is bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| strobe_i | input | 1 | One-cycle pulse marking a new entered value |
| value_i | input | 4 | Entered value |
| combo_i | input | 12 | Stored digits; digit k in bits [4k-1:4k-4] |
| open_o | output | 1 | 1 = lock open, 0 = closed |

## Verification
On every cycle, the assertions check four properties of the state register. It is at most one-hot. Open and error are sticky. The state holds whenever no strobe arrives. A strobe moves the state one position on a match and to zero on a mismatch. Only the bench scenarios can show the end-to-end effects. These are: the lock opens on exactly the right sequence, and a wrong digit at each position with each wrong value keeps it closed for good. They also show that values presented without a strobe are ignored, and that a mid-sequence reset forces a fresh entry.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int unsigned VAL_W      = 4;
  localparam int unsigned NUM_DIGITS = 3;
  localparam int unsigned ST_W       = NUM_DIGITS + 1;
endpackage

// File: rtl/lock_rst_sync.sv
module lock_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lock_digit_sel.sv
module lock_digit_sel #(
  parameter int unsigned VAL_W      = 4,
  parameter int unsigned NUM_DIGITS = 3
) (
  input  logic [NUM_DIGITS-1:0]       sel_i,
  input  logic [NUM_DIGITS*VAL_W-1:0] combo_i,
  output logic [VAL_W-1:0]            digit_o
);
  logic [VAL_W-1:0] term [NUM_DIGITS];

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_term
    assign term[k] = {VAL_W{sel_i[k]}} & combo_i[k*VAL_W +: VAL_W];
  end

  always_comb begin
    digit_o = '0;
    for (int k = 0; k < NUM_DIGITS; k++) digit_o = digit_o | term[k];
  end
endmodule

// File: rtl/lock_cmp.sv
module lock_cmp #(
  parameter int unsigned VAL_W = 4
) (
  input  logic [VAL_W-1:0] a_i,
  input  logic [VAL_W-1:0] b_i,
  output logic             equal_o
);
  assign equal_o = (a_i == b_i);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm #(
  parameter int unsigned NUM_DIGITS = 3,
  localparam int unsigned ST_W = NUM_DIGITS + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_i,
  input  logic            equal_i,
  output logic [ST_W-1:0] state_o
);
  localparam logic [ST_W-1:0] ST_FIRST = ST_W'(1);
  localparam logic [ST_W-1:0] ST_ERR   = '0;

  logic [ST_W-1:0] state_q, state_d;
  logic            active;
  logic            load_en;

  assign active  = |state_q[NUM_DIGITS-1:0];
  assign load_en = active & strobe_i;

  always_comb begin
    state_d = state_q;
    if (load_en) begin
      if (equal_i) state_d = state_q << 1;
      else         state_d = ST_ERR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= ST_FIRST;
    else if (load_en) state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
  import lock_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        strobe_i,
  input  logic [VAL_W-1:0]            value_i,
  input  logic [NUM_DIGITS*VAL_W-1:0] combo_i,
  output logic                        open_o
);
  logic            rst_sync_n;
  logic [ST_W-1:0] state_q;
  logic [VAL_W-1:0] digit;
  logic            equal;

  lock_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lock_digit_sel #(.VAL_W(VAL_W), .NUM_DIGITS(NUM_DIGITS)) u_sel (
    .sel_i(state_q[NUM_DIGITS-1:0]), .combo_i(combo_i), .digit_o(digit)
  );

  lock_cmp #(.VAL_W(VAL_W)) u_cmp (
    .a_i(digit), .b_i(value_i), .equal_o(equal)
  );

  lock_fsm #(.NUM_DIGITS(NUM_DIGITS)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .strobe_i(strobe_i),
    .equal_i(equal), .state_o(state_q)
  );

  assign open_o = state_q[NUM_DIGITS];
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk
  import lock_pkg::*;
(
  input logic            clk,
  input logic            rst_sync_n,
  input logic            strobe_i,
  input logic            equal,
  input logic [ST_W-1:0] state_q
);
  logic active;
  assign active = |state_q[NUM_DIGITS-1:0];

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(state_q)); // R8
  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    state_q[NUM_DIGITS] |=> state_q[NUM_DIGITS]); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == '0) |=> (state_q == '0)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !strobe_i |=> $stable(state_q)); // R3
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_i && active && equal) |=> (state_q == ($past(state_q) << 1))); // R2
  AST_MISMATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (strobe_i && active && !equal) |=> (state_q == '0)); // R4
endmodule

bind combo_lock_ctrl combo_lock_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .strobe_i(strobe_i),
  .equal(equal), .state_q(state_q)
);

// File: tb/combo_lock_ctrl_bench.sv
`timescale 1ns/1ps
module combo_lock_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [3:0]  value = 4'h0;
  logic [11:0] combo = 12'h000;
  logic        open_w;
  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  int          model;  // 0..2 digit pos, 3 open, 4 error

  always #4 clk = ~clk;

  combo_lock_ctrl u_combo_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .value_i(value),
    .combo_i(combo), .open_o(open_w)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [3:0] dig(input int k);
    return combo[k*4 +: 4];
  endfunction

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (open_w !== exp) begin
      n_bad++;
      $display("FAIL %s: open act=%b exp=%b", req, open_w, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; strobe = 1'b0;
    @(negedge clk); check("R1", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    model = 0;
  endtask

  task automatic enter(input logic [3:0] v, input string req);
    @(negedge clk); value = v; strobe = 1'b1;
    @(negedge clk); strobe = 1'b0; value = ~v;
    if (model < 3) model = (v == dig(model)) ? model + 1 : 4;
    check(req, model == 3);
  endtask

  task automatic idle_noise(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); value = 4'(i * 7 + 3);
    end
    @(negedge clk);
    check(req, model == 3);
  endtask

  initial begin
    logic [11:0] combos [3];
    combos[0] = 12'h243; combos[1] = 12'hF0A; combos[2] = 12'h555;
    combo = combos[0];
    do_reset();
    for (int c = 0; c < 3; c++) begin
      combo = combos[c];
      // full correct sequence, with noise between digits
      do_reset();
      enter(dig(0), "R2"); idle_noise(3, "R3");
      enter(dig(1), "R2"); idle_noise(2, "R3");
      enter(dig(2), "R2");
      enter(~dig(0), "R5"); enter(dig(0), "R5"); idle_noise(2, "R5");
      // mismatch at every position with every wrong value
      for (int p = 0; p < 3; p++) begin
        for (int w = 0; w < 16; w++) begin
          if (4'(w) == dig(p)) continue;
          do_reset();
          for (int k = 0; k < p; k++) enter(dig(k), "R2");
          enter(4'(w), "R4");
          for (int k = p + 1; k < 3; k++) enter(dig(k), "R6");
          enter(dig(0), "R6"); enter(dig(1), "R6"); enter(dig(2), "R6");
        end
      end
      // reset in the middle of a sequence
      for (int p = 1; p < 4; p++) begin
        do_reset();
        for (int k = 0; k < p; k++) enter(dig(k), "R2");
        do_reset();
        check("R7", 1'b0);
        for (int k = p; k < 3; k++) enter(dig(k), "R7");
        do_reset();
        for (int k = 0; k < 3; k++) enter(dig(k), "R7");
      end
    end
    // R8: digits occupy fixed nibbles; swapped order must not open
    combo = 12'h321;
    do_reset();
    enter(4'h3, "R8"); enter(4'h2, "R8"); enter(4'h1, "R8");
    do_reset();
    enter(4'h1, "R8"); enter(4'h2, "R8"); enter(4'h3, "R8");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule